// File: doc/BRIEF.md
# Wake Event Latch Aggregator

This block gathers up to eight wake and status events and presents them in two forms. Software sees them as a status word. A supply controller sees them as a single registered turn-on request. Each event line is first brought into the clock domain through a two-flop synchronizer. It is then treated according to a 2-bit type code that configuration logic supplies for that line.

A wake-latched line captures a rising edge and keeps it until software reads the status, and that held bit requests supply turn-on. A level line has no memory: its status bit and its turn-on contribution both follow the synchronized level, and the source clears it. A status-latched line captures and holds edges the same way, but it never asks for turn-on. A line coded as off shows nothing and requests nothing. A read strobe returns the status word in the same cycle and clears the latched bits that the word returned. The one exception is a bit that sees a fresh edge during that cycle: that bit stays set.

Top module: `wake_event_agg`

## Requirements
- R1: While reset is held and just after it is released, `rd_data` is all zero and `pwr_req` is 0.
- R2: The type code for line i is `evt_type[2i+1:2i]`: 00 = off, 01 = wake-latched, 10 = level, 11 = status-latched. An off line always reads 0 and never raises `pwr_req`.
- R3: On a wake-latched line, a rising edge of the synchronized input sets its status bit. The bit stays 1 after the input falls, until it is cleared by a read.
- R4: A set wake-latched bit raises `pwr_req` exactly one clock after the bit becomes 1.
- R5: On a level line, the status bit equals the synchronized input, and a read strobe does not change it.
- R6: A high level line raises `pwr_req` one clock after its status bit becomes 1. `pwr_req` drops one clock after the bit returns to 0.
- R7: A status-latched line captures and holds rising edges in the same way as R3.
- R8: A status-latched bit never raises `pwr_req`.
- R9: `rd_data` is the live status word. A cycle with `rd_stb` high clears every latched bit that this word returned as 1.
- R10: If a new synchronized rising edge occurs on a latched line during the cycle of a clearing read, that bit remains 1 after the read.
- R11: Timing, counting from the first rising clock edge that samples a changed input: a level status bit changes after the second edge. A latched status bit sets after the third edge.
- R12: Events are active high. A falling edge of the input never sets a latched bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | N_EVT | Raw asynchronous event lines, active high |
| evt_type | input | 2*N_EVT | Per-line type code, 2 bits per line |
| rd_stb | input | 1 | Status read strobe; clears returned latched bits |
| rd_data | output | N_EVT | Live status word |
| pwr_req | output | 1 | Registered supply turn-on request |

## Verification
Every one of the four type codes is applied in turn to every one of the eight lines. Each line gets a single rising pulse, which is then released and then read. This tells apart holding from following, and requesting from silent latching. It also confirms that no other line picks up stray status. Sampling edge by edge after each input change separates the synchronizer delay from the latch delay and from the one-clock request delay. Three directed patterns complete the set. The first is a read that coincides with a new edge, which shows the edge is kept. The second is a read of a held-high level line, which shows reads leave levels alone. The third is a falling input on a cleared wake line, which shows edges are detected only in the active-high direction.

// File: rtl/wake_event_agg.sv
module wake_event_agg #(
  parameter int N_EVT       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_EVT-1:0]     evt_in,
  input  logic [2*N_EVT-1:0]   evt_type,
  input  logic                 rd_stb,
  output logic [N_EVT-1:0]     rd_data,
  output logic                 pwr_req
);

  localparam logic [1:0] T_OFF   = 2'b00;
  localparam logic [1:0] T_WAKE  = 2'b01;
  localparam logic [1:0] T_LEVEL = 2'b10;
  localparam logic [1:0] T_STAT  = 2'b11;

  logic [SYNC_STAGES-1:0][N_EVT-1:0] sync_pipe;
  logic [N_EVT-1:0] sync_lvl, sync_prev, latch_q;
  logic [N_EVT-1:0] m_wake, m_level, m_stat, m_off, m_latch;
  logic [N_EVT-1:0] edge_hit, clr_mask;

  for (genvar i = 0; i < N_EVT; i++) begin : g_type
    assign m_off[i]   = evt_type[2*i +: 2] == T_OFF;
    assign m_wake[i]  = evt_type[2*i +: 2] == T_WAKE;
    assign m_level[i] = evt_type[2*i +: 2] == T_LEVEL;
    assign m_stat[i]  = evt_type[2*i +: 2] == T_STAT;
  end

  assign m_latch  = m_wake | m_stat;
  assign sync_lvl = sync_pipe[SYNC_STAGES-1];
  assign edge_hit = sync_lvl & ~sync_prev & m_latch;
  assign clr_mask = rd_stb ? rd_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_pipe <= '0;
      sync_prev <= '0;
    end else begin
      sync_pipe <= {sync_pipe[SYNC_STAGES-2:0], evt_in};
      sync_prev <= sync_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= ((latch_q & ~clr_mask) | edge_hit) & m_latch;
  end

  assign rd_data = (latch_q & m_latch & ~m_off) | (sync_lvl & m_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_req <= 1'b0;
    else        pwr_req <= |((latch_q & m_wake) | (sync_lvl & m_level));
  end

endmodule

// File: rtl/wake_event_agg_chk.sv
module wake_event_agg_chk #(
  parameter int N_EVT = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2*N_EVT-1:0] evt_type,
  input logic               rd_stb,
  input logic [N_EVT-1:0]   rd_data,
  input logic               pwr_req,
  input logic [N_EVT-1:0]   sync_lvl
);

  logic [N_EVT-1:0] c_off, c_lat, c_req;

  for (genvar i = 0; i < N_EVT; i++) begin : g_m
    assign c_off[i] = evt_type[2*i +: 2] == 2'b00;
    assign c_lat[i] = evt_type[2*i] == 1'b1;
    assign c_req[i] = evt_type[2*i +: 2] == 2'b01 || evt_type[2*i +: 2] == 2'b10;
  end

  // R2
  off_line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_off & rd_data) == '0);

  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(evt_type) && !$past(rd_stb)) |-> ((c_lat & $past(rd_data) & ~rd_data) == '0));

  // R4
  req_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(evt_type) |-> (pwr_req == $past(|(rd_data & c_req))));

  // R12
  set_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(evt_type) |-> ((c_lat & rd_data & ~$past(rd_data) & ~$past(sync_lvl)) == '0));

  // R10
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_stb) && $stable(evt_type)) |-> ((c_lat & $past(rd_data) & rd_data & ~$past(sync_lvl)) == '0));

endmodule

bind wake_event_agg wake_event_agg_chk #(.N_EVT(N_EVT)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_type(evt_type), .rd_stb(rd_stb),
  .rd_data(rd_data), .pwr_req(pwr_req), .sync_lvl(sync_lvl)
);

// File: tb/wake_event_agg_test.sv
`timescale 1ns/1ps
module wake_event_agg_test;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] evt_in = '0;
  logic [2*N-1:0] evt_type = '0;
  logic         rd_stb = 1'b0;
  logic [N-1:0] rd_data;
  logic         pwr_req;
  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  wake_event_agg #(.N_EVT(N)) uut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .evt_type(evt_type),
    .rd_stb(rd_stb), .rd_data(rd_data), .pwr_req(pwr_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; evt_in = '0; rd_stb = 1'b0;
    step(2);
    rst_n = 1'b1;
  endtask

  function automatic logic [2*N-1:0] all_type(input logic [1:0] t);
    logic [2*N-1:0] v;
    for (int j = 0; j < N; j++) v[2*j +: 2] = t;
    return v;
  endfunction

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(2);
    check("R1 reset rd_data", rd_data, 0);
    check("R1 reset pwr_req", pwr_req, 0);
    rst_n = 1'b1;
    step(1);
    check("R1 after release rd_data", rd_data, 0);
    check("R1 after release pwr_req", pwr_req, 0);

    for (int t = 0; t < 4; t++) begin
      for (int i = 0; i < N; i++) begin
        logic [N-1:0] bitv;
        logic lat, lvl, wk;
        bitv = N'(1) << i;
        lat = (t == 1) || (t == 3);
        lvl = (t == 2);
        wk  = (t == 1);
        do_reset();
        evt_type = all_type(2'(t));
        evt_in = bitv;
        step(1);
        check("R11 one edge no status", rd_data, 0);
        step(1);
        check("R11 R5 level after two edges", rd_data, lvl ? bitv : '0);
        check("R6 no req yet", pwr_req, 0);
        step(1);
        check("R3 R7 R2 status after three edges", rd_data, (lat || lvl) ? bitv : '0);
        check("R6 R2 level req", pwr_req, lvl);
        step(1);
        check("R4 R8 R2 req one clock later", pwr_req, wk || lvl);
        evt_in = '0;
        step(3);
        check("R3 R7 R5 hold after input low", rd_data, lat ? bitv : '0);
        check("R6 R4 req after input low", pwr_req, wk);
        rd_stb = 1'b1;
        check("R9 read returns status", rd_data, lat ? bitv : '0);
        step(1);
        rd_stb = 1'b0;
        check("R9 read clears", rd_data, 0);
        step(1);
        check("R4 req drops after clear", pwr_req, 0);
      end
    end

    // R10 coincident edge and read
    do_reset();
    evt_type = all_type(2'b01);
    evt_in = 8'h01;
    step(4);
    evt_in = 8'h00;
    step(4);
    check("R10 pre latched", rd_data, 8'h01);
    evt_in = 8'h01;
    step(2);
    rd_stb = 1'b1;
    check("R10 read returns bit", rd_data, 8'h01);
    step(1);
    rd_stb = 1'b0;
    check("R10 bit kept on coincident edge", rd_data, 8'h01);
    rd_stb = 1'b1;
    step(1);
    rd_stb = 1'b0;
    check("R9 later read clears", rd_data, 8'h00);

    // R12 falling edge does not set
    step(2);
    evt_in = 8'h00;
    step(5);
    check("R12 falling edge ignored", rd_data, 8'h00);
    check("R12 no req", pwr_req, 0);

    // R5 read leaves level line alone
    do_reset();
    evt_type = all_type(2'b10);
    evt_in = 8'h80;
    step(3);
    rd_stb = 1'b1;
    step(1);
    rd_stb = 1'b0;
    check("R5 level unaffected by read", rd_data, 8'h80);
    check("R6 level req held", pwr_req, 1);

    // R8 mixed: status-latched lines only
    do_reset();
    evt_type = all_type(2'b11);
    evt_in = 8'hFF;
    step(5);
    check("R7 all status lines set", rd_data, 8'hFF);
    check("R8 no req from status lines", pwr_req, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule